// File: doc/BRIEF.md
# Frame Exposure Controller with Two-Frame Update Latency

This block works out the integration time that a sensor uses for each frame. Integration has two parts: a whole-row part (coarse rows times the row period) and a sub-row part (fine pixel clocks). Each of the two contexts, A and B, has its own manual coarse register, fine register and row period. The coarse row count comes either from the active context's manual register or from an automatic-exposure request. An automatic request is clamped between a programmable lower limit and a programmable upper limit. The fine count always comes from the active context.

New settings never reach the outputs straight away. A two-stage pipeline advances on every falling edge of frame-valid. Settings that are present while frame n is being read out are therefore applied from frame n+2 onwards. The block also compares the applied coarse row count with the programmed frame length. It raises a flag, and gives the number of extra blanking rows, when the exposure would stretch the frame.

Top module: `expo_ctrl`

## Requirements
- R1: After reset, `int_rows`, `int_fine`, `int_clocks`, `extra_blank_rows` and `apply_pulse` are zero and `over_frame` is low.
- R2: `int_clocks` equals `int_rows` times the applied row period, plus `int_fine`. All quantities are in master-clock periods.
- R3: With automatic exposure off, the coarse rows come from `man_rows_a` when `ctx_b` is 0 and from `man_rows_b` when `ctx_b` is 1.
- R4: `ae_ctrl` bit 0 enables automatic exposure for context A, and bit 8 enables it for context B. Only the bit of the active context matters. Every other bit of `ae_ctrl` has no effect.
- R5: With automatic exposure on and `ae_min_rows` <= `ae_max_rows`, the coarse rows are `ae_req_rows` clamped into [`ae_min_rows`, `ae_max_rows`].
- R6: With automatic exposure on and `ae_min_rows` > `ae_max_rows`, the coarse rows equal `ae_max_rows`, whatever the request is.
- R7: The fine count and the row period come from the active context (`fine_a`/`row_time_a` when `ctx_b` is 0, `fine_b`/`row_time_b` when it is 1), in both modes.
- R8: The settings present on the clock edge where a frame-valid fall is detected are captured. They reach the outputs on the next detected fall, not before. Between falls, the outputs hold.
- R9: `over_frame` is high exactly when the applied coarse rows are strictly greater than the applied `frame_rows`. `extra_blank_rows` is then their difference, and otherwise it is zero.
- R10: `apply_pulse` is high for exactly one clock, starting on the edge after which the new outputs are visible, once per frame-valid fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | High while a frame is read out |
| ae_ctrl | input | CTRL_W | Exposure control word, bit 0 = auto A, bit 8 = auto B |
| ctx_b | input | 1 | 0 selects context A, 1 selects context B |
| man_rows_a | input | ROW_W | Manual coarse rows, context A |
| man_rows_b | input | ROW_W | Manual coarse rows, context B |
| fine_a | input | FINE_W | Fine pixel clocks, context A |
| fine_b | input | FINE_W | Fine pixel clocks, context B |
| row_time_a | input | RT_W | Row period in clocks, context A |
| row_time_b | input | RT_W | Row period in clocks, context B |
| ae_req_rows | input | ROW_W | Coarse rows asked for by automatic exposure |
| ae_min_rows | input | ROW_W | Lower clamp limit |
| ae_max_rows | input | ROW_W | Upper clamp limit |
| frame_rows | input | ROW_W | Total rows per frame including blanking |
| int_rows | output | ROW_W | Applied coarse rows |
| int_fine | output | FINE_W | Applied fine clocks |
| int_clocks | output | ROW_W+RT_W+1 | Applied total integration in clocks |
| over_frame | output | 1 | Coarse rows exceed the frame length |
| extra_blank_rows | output | ROW_W | Extra blanking rows needed |
| apply_pulse | output | 1 | One-clock strobe when new settings apply |

## Verification
A settings change and a pipeline advance can happen in the same cycle: a register can be rewritten on exactly the clock edge where the frame-valid fall is detected. The bench provokes this by driving the new settings and the low frame-valid on the same half-cycle. It then checks that the outputs keep the old values after that fall and show the new values only after the following fall. The overrun comparison is judged in the same cycle as the advance that brings a long exposure into the second stage, so the flag and the extra row count must change together with `int_rows`.

// File: rtl/expo_pkg.sv
package expo_pkg;
  // Which bit of the control word enables automatic exposure for each context.
  localparam int AE_BIT_A = 0;
  localparam int AE_BIT_B = 8;

  typedef enum logic {CTX_A = 1'b0, CTX_B = 1'b1} ctx_e;
endpackage

// File: rtl/expo_select.sv
module expo_select
  import expo_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int FINE_W = 10,
  parameter int RT_W   = 12,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ae_ctrl,
  input  logic              ctx_b,
  input  logic [ROW_W-1:0]  man_rows_a,
  input  logic [ROW_W-1:0]  man_rows_b,
  input  logic [FINE_W-1:0] fine_a,
  input  logic [FINE_W-1:0] fine_b,
  input  logic [RT_W-1:0]   row_time_a,
  input  logic [RT_W-1:0]   row_time_b,
  input  logic [ROW_W-1:0]  ae_req_rows,
  input  logic [ROW_W-1:0]  ae_min_rows,
  input  logic [ROW_W-1:0]  ae_max_rows,
  output logic [ROW_W-1:0]  sel_rows,
  output logic [FINE_W-1:0] sel_fine,
  output logic [RT_W-1:0]   sel_rt,
  output logic              auto_on
);
  // The upper limit wins when the limits cross.
  function automatic logic [ROW_W-1:0] clamp_rows(
    input logic [ROW_W-1:0] req,
    input logic [ROW_W-1:0] lo,
    input logic [ROW_W-1:0] hi
  );
    logic [ROW_W-1:0] floor_v;
    floor_v = (lo > hi) ? hi : lo;
    if (req < floor_v)   return floor_v;
    else if (req > hi)   return hi;
    else                 return req;
  endfunction

  ctx_e             ctx;
  logic [ROW_W-1:0] manual_rows;
  logic [ROW_W-1:0] auto_rows;

  assign ctx = ctx_e'(ctx_b);

  always_comb begin
    auto_on     = (ctx == CTX_B) ? ae_ctrl[AE_BIT_B] : ae_ctrl[AE_BIT_A];
    manual_rows = (ctx == CTX_B) ? man_rows_b : man_rows_a;
    auto_rows   = clamp_rows(ae_req_rows, ae_min_rows, ae_max_rows);
    sel_rows    = auto_on ? auto_rows : manual_rows;
    sel_fine    = (ctx == CTX_B) ? fine_b : fine_a;
    sel_rt      = (ctx == CTX_B) ? row_time_b : row_time_a;
  end

  AST_CLAMP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && ae_min_rows <= ae_max_rows) |->
      (sel_rows >= ae_min_rows && sel_rows <= ae_max_rows)); // R5

  AST_CROSSED_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_on && ae_min_rows > ae_max_rows) |-> sel_rows == ae_max_rows); // R6
endmodule

// File: rtl/expo_pipe.sv
module expo_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_valid,
  input  logic [W-1:0] cfg_in,
  output logic [W-1:0] cfg_applied,
  output logic         fv_fall,
  output logic         apply_pulse
);
  logic         fv_q;
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  assign fv_fall     = fv_q & ~frame_valid;
  assign cfg_applied = stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q        <= 1'b0;
      stage1      <= '0;
      stage2      <= '0;
      apply_pulse <= 1'b0;
    end else begin
      fv_q        <= frame_valid;
      apply_pulse <= fv_fall;
      if (fv_fall) begin
        stage1 <= cfg_in;
        stage2 <= stage1;
      end
    end
  end

  AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    fv_fall |=> stage2 == $past(stage1)); // R8

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !fv_fall |=> $stable(stage2)); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |=> !apply_pulse); // R10
endmodule

// File: rtl/expo_calc.sv
module expo_calc #(
  parameter int ROW_W  = 12,
  parameter int FINE_W = 10,
  parameter int RT_W   = 12,
  parameter int TIME_W = ROW_W + RT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  rows,
  input  logic [FINE_W-1:0] fine,
  input  logic [RT_W-1:0]   row_time,
  input  logic [ROW_W-1:0]  frame_len,
  output logic [TIME_W-1:0] total_clocks,
  output logic              over,
  output logic [ROW_W-1:0]  extra_rows
);
  function automatic logic [TIME_W-1:0] integ_clocks(
    input logic [ROW_W-1:0]  r,
    input logic [RT_W-1:0]   t,
    input logic [FINE_W-1:0] f
  );
    return TIME_W'(r) * TIME_W'(t) + TIME_W'(f);
  endfunction

  function automatic logic [ROW_W-1:0] blank_shortfall(
    input logic [ROW_W-1:0] r,
    input logic [ROW_W-1:0] len
  );
    return (r > len) ? (r - len) : '0;
  endfunction

  always_comb begin
    total_clocks = integ_clocks(rows, row_time, fine);
    extra_rows   = blank_shortfall(rows, frame_len);
    over         = rows > frame_len;
  end

  AST_OVER_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    over |-> (extra_rows != '0 && extra_rows + frame_len == rows)); // R9

  AST_NO_OVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !over |-> extra_rows == '0); // R9

  AST_FINE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    total_clocks >= TIME_W'(fine)); // R2
endmodule

// File: rtl/expo_ctrl.sv
module expo_ctrl #(
  parameter int ROW_W  = 12,
  parameter int FINE_W = 10,
  parameter int RT_W   = 12,
  parameter int CTRL_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_valid,
  input  logic [CTRL_W-1:0]       ae_ctrl,
  input  logic                    ctx_b,
  input  logic [ROW_W-1:0]        man_rows_a,
  input  logic [ROW_W-1:0]        man_rows_b,
  input  logic [FINE_W-1:0]       fine_a,
  input  logic [FINE_W-1:0]       fine_b,
  input  logic [RT_W-1:0]         row_time_a,
  input  logic [RT_W-1:0]         row_time_b,
  input  logic [ROW_W-1:0]        ae_req_rows,
  input  logic [ROW_W-1:0]        ae_min_rows,
  input  logic [ROW_W-1:0]        ae_max_rows,
  input  logic [ROW_W-1:0]        frame_rows,
  output logic [ROW_W-1:0]        int_rows,
  output logic [FINE_W-1:0]       int_fine,
  output logic [ROW_W+RT_W:0]     int_clocks,
  output logic                    over_frame,
  output logic [ROW_W-1:0]        extra_blank_rows,
  output logic                    apply_pulse
);
  localparam int TIME_W = ROW_W + RT_W + 1;
  localparam int PIPE_W = 2 * ROW_W + FINE_W + RT_W;

  logic [ROW_W-1:0]  sel_rows;
  logic [FINE_W-1:0] sel_fine;
  logic [RT_W-1:0]   sel_rt;
  logic              auto_on;
  logic [PIPE_W-1:0] cfg_live;
  logic [PIPE_W-1:0] cfg_applied;
  logic              fv_fall;
  logic [RT_W-1:0]   app_rt;
  logic [ROW_W-1:0]  app_len;

  expo_select #(.ROW_W(ROW_W), .FINE_W(FINE_W), .RT_W(RT_W), .CTRL_W(CTRL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .ae_ctrl(ae_ctrl), .ctx_b(ctx_b),
    .man_rows_a(man_rows_a), .man_rows_b(man_rows_b),
    .fine_a(fine_a), .fine_b(fine_b),
    .row_time_a(row_time_a), .row_time_b(row_time_b),
    .ae_req_rows(ae_req_rows), .ae_min_rows(ae_min_rows), .ae_max_rows(ae_max_rows),
    .sel_rows(sel_rows), .sel_fine(sel_fine), .sel_rt(sel_rt), .auto_on(auto_on)
  );

  // Frame length travels with the exposure so both apply in the same frame.
  assign cfg_live = {frame_rows, sel_rt, sel_fine, sel_rows};

  expo_pipe #(.W(PIPE_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
    .cfg_in(cfg_live), .cfg_applied(cfg_applied),
    .fv_fall(fv_fall), .apply_pulse(apply_pulse)
  );

  assign {app_len, app_rt, int_fine, int_rows} = cfg_applied;

  expo_calc #(.ROW_W(ROW_W), .FINE_W(FINE_W), .RT_W(RT_W), .TIME_W(TIME_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .rows(int_rows), .fine(int_fine),
    .row_time(app_rt), .frame_len(app_len),
    .total_clocks(int_clocks), .over(over_frame), .extra_rows(extra_blank_rows)
  );

  AST_MANUAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fv_fall && !auto_on) |=> u_pipe.stage1[ROW_W-1:0] ==
      ($past(ctx_b) ? $past(man_rows_b) : $past(man_rows_a))); // R3

  AST_OUT_ON_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply_pulse && $past(rst_n)) |-> $stable(int_clocks)); // R8
endmodule

// File: tb/tb_expo_ctrl.sv
module tb_expo_ctrl;
  localparam int ROW_W = 12, FINE_W = 10, RT_W = 12, CTRL_W = 16;
  localparam int TIME_W = ROW_W + RT_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_valid = 1'b0;
  logic [CTRL_W-1:0] ae_ctrl = '0;
  logic ctx_b = 1'b0;
  logic [ROW_W-1:0] man_rows_a = '0, man_rows_b = '0;
  logic [FINE_W-1:0] fine_a = '0, fine_b = '0;
  logic [RT_W-1:0] row_time_a = '0, row_time_b = '0;
  logic [ROW_W-1:0] ae_req_rows = '0, ae_min_rows = '0, ae_max_rows = '0, frame_rows = '0;
  logic [ROW_W-1:0] int_rows;
  logic [FINE_W-1:0] int_fine;
  logic [TIME_W-1:0] int_clocks;
  logic over_frame;
  logic [ROW_W-1:0] extra_blank_rows;
  logic apply_pulse;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  expo_ctrl #(.ROW_W(ROW_W), .FINE_W(FINE_W), .RT_W(RT_W), .CTRL_W(CTRL_W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .ae_ctrl(ae_ctrl), .ctx_b(ctx_b),
    .man_rows_a(man_rows_a), .man_rows_b(man_rows_b), .fine_a(fine_a), .fine_b(fine_b),
    .row_time_a(row_time_a), .row_time_b(row_time_b), .ae_req_rows(ae_req_rows),
    .ae_min_rows(ae_min_rows), .ae_max_rows(ae_max_rows), .frame_rows(frame_rows),
    .int_rows(int_rows), .int_fine(int_fine), .int_clocks(int_clocks),
    .over_frame(over_frame), .extra_blank_rows(extra_blank_rows), .apply_pulse(apply_pulse)
  );

  typedef struct packed {
    logic        cb;
    logic [15:0] ae;
    logic [11:0] ma, mb;
    logic [9:0]  fa, fb;
    logic [11:0] ta, tb, req, mn, mx, fr;
  } vec_t;

  // cb, ae, ma, mb, fa, fb, ta, tb, req, mn, mx, fr
  localparam vec_t VECS [10] = '{
    '{1'b0, 16'h0000, 12'd100, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd50,  12'd1,   12'd480, 12'd525}, // R3 A manual
    '{1'b1, 16'h0000, 12'd100, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd50,  12'd1,   12'd480, 12'd525}, // R3 R7 B manual
    '{1'b0, 16'h0001, 12'd100, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd50,  12'd60,  12'd400, 12'd525}, // R5 low clamp
    '{1'b0, 16'h0001, 12'd100, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd900, 12'd1,   12'd480, 12'd525}, // R5 high clamp
    '{1'b1, 16'h0100, 12'd100, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd300, 12'd10,  12'd400, 12'd525}, // R4 R7 B auto
    '{1'b1, 16'h0001, 12'd100, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd300, 12'd10,  12'd400, 12'd525}, // R4 A bit, ctx B
    '{1'b0, 16'hFEFE, 12'd100, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd300, 12'd10,  12'd400, 12'd525}, // R4 spare bits
    '{1'b0, 16'h0001, 12'd100, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd5,   12'd300, 12'd200, 12'd525}, // R6 crossed
    '{1'b0, 16'h0000, 12'd600, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd5,   12'd1,   12'd480, 12'd525}, // R9 over
    '{1'b0, 16'h0000, 12'd525, 12'd200, 10'd10, 10'd20, 12'd700, 12'd800, 12'd5,   12'd1,   12'd480, 12'd525}  // R9 equal
  };

  function automatic int exp_rows(vec_t v);
    bit auto_en = v.cb ? v.ae[8] : v.ae[0];
    if (!auto_en) return v.cb ? int'(v.mb) : int'(v.ma);
    if (v.mx < v.mn) return int'(v.mx);
    if (v.req > v.mx) return int'(v.mx);
    if (v.req < v.mn) return int'(v.mn);
    return int'(v.req);
  endfunction

  task automatic drive(vec_t v);
    ctx_b = v.cb; ae_ctrl = v.ae; man_rows_a = v.ma; man_rows_b = v.mb;
    fine_a = v.fa; fine_b = v.fb; row_time_a = v.ta; row_time_b = v.tb;
    ae_req_rows = v.req; ae_min_rows = v.mn; ae_max_rows = v.mx; frame_rows = v.fr;
  endtask

  task automatic one_frame();
    frame_valid = 1'b1;
    repeat (6) @(negedge clk);
    frame_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_vec(vec_t v);
    int r = exp_rows(v);
    int f = v.cb ? int'(v.fb) : int'(v.fa);
    int t = v.cb ? int'(v.tb) : int'(v.ta);
    chk("R3/R5 rows", int_rows, r);
    chk("R7 fine", int_fine, f);
    chk("R2 clocks", int_clocks, longint'(r) * t + f);
    chk("R9 over", over_frame, (r > int'(v.fr)) ? 1 : 0);
    chk("R9 extra", extra_blank_rows, (r > int'(v.fr)) ? r - int'(v.fr) : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rows", int_rows, 0);
    chk("R1 fine", int_fine, 0);
    chk("R1 clocks", int_clocks, 0);
    chk("R1 over", over_frame, 0);
    chk("R1 extra", extra_blank_rows, 0);
    chk("R1 pulse", apply_pulse, 0);

    foreach (VECS[i]) begin
      drive(VECS[i]);
      one_frame();
      one_frame();
      check_vec(VECS[i]);
    end

    // R8: change during a frame shows only after two falls
    drive(VECS[0]); one_frame(); one_frame();
    drive(VECS[1]);
    one_frame();
    chk("R8 held after first fall", int_rows, 100);
    one_frame();
    chk("R8 applied after second fall", int_rows, 200);

    // R8: change on the very cycle of the frame-valid fall is captured by that fall
    frame_valid = 1'b1;
    repeat (6) @(negedge clk);
    frame_valid = 1'b0;
    drive(VECS[8]);
    repeat (3) @(negedge clk);
    chk("R8 same-cycle not yet", int_rows, 200);
    chk("R9 same-cycle not yet", over_frame, 0);
    one_frame();
    chk("R8 same-cycle applied", int_rows, 600);
    chk("R9 same-cycle flag", over_frame, 1);
    chk("R9 same-cycle extra", extra_blank_rows, 75);

    // R10 pulse timing
    frame_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle", apply_pulse, 0);
    frame_valid = 1'b0;
    @(negedge clk);
    chk("R10 high", apply_pulse, 1);
    @(negedge clk);
    chk("R10 single", apply_pulse, 0);

    // R8: outputs hold while frame-valid stays low and settings change
    drive(VECS[4]);
    repeat (10) @(negedge clk);
    chk("R8 hold without fall", int_rows, 600);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule